// File: doc/BRIEF.md
# Command-Driven Random Generator Controller

This block is a register-mapped controller around a 32-bit pseudo-random generator. Software writes a command code to the control register to either reseed the generator or produce a block of random data. While a command runs, a status register shows which operation is busy. When it finishes, the result sits in eight 32-bit output words. A mode bit selects whether the block is 128 or 256 bits wide.

Completion of a generate, completion of a reseed, and a generator stuck at zero each latch an interrupt cause. Each cause can be masked, and writing a one clears it. A global enable gates the single interrupt line. Two reload registers let the block reseed on its own: one after a programmed number of served generate requests, the other when an age timer runs out.

The seed comes from a free-running internal source. In nonce mode it comes instead from a software-written field, which makes the output deterministic. Reads are combinational from `rd_addr`. Writes take effect at the clock edge on which `wr_en` is sampled high.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: After reset, every status bit, interrupt cause and output word reads 0, and `irq` is low.
- R2: Writing code 2 to the control register (0x00) while idle sets status bit 31. Exactly 16 cycles after the write edge, bit 31 clears, status bit 9 (seeded) sets and cause bit 1 sets in the cause register (0x14).
- R3: Writing code 1 while idle and seeded sets status bit 30 for 8 cycles, then sets cause bit 0.
- R3 (output words): Output word k (address 0x20+4k) holds the generator state after k+1 steps of the Galois LFSR next = (s>>1) ^ (s[0] ? 0x80200003 : 0). Successive generates continue from the last state.
- R4: With nonce mode on (register 0x0C bit 2), a reseed loads the state {F,F}, where F is bits 31:16 of register 0x0C. With nonce mode off, the seed is a nonzero internal value.
- R5: With register 0x08 bit 3 clear, output words 4 to 7 read 0. With the bit set, all eight words are valid.
- R6: These commands have no effect at the ports:
  - a generate before the first reseed;
  - any command written while busy;
  - codes 0 and 3 and above.
- R7: Writing a 1 to a bit of the cause register clears that bit. Writing a 0 leaves it unchanged.
- R8: `irq` is high only when register 0x10 bit 31 is set and some cause bit 0, 1 or 4 is set together with the matching enable bit of 0x10.
- R9: With a nonzero value N in register 0x60, the Nth served generate starts a reseed on its completion edge. That reseed sets cause bit 1. A value of 0 disables this.
- R10: With a nonzero value N written to register 0x64, a reseed starts N cycles after the write edge. Any reseed reloads the timer. A value of 0 disables it.
- R11: While the block is seeded and the state is zero, status bit 27 reads 1. One cycle after the state becomes zero, cause bit 4 sets. A reseed with a nonzero seed clears bit 27.
- R12: Status bits 2, 3 and 8 mirror nonce mode, 256-bit mode and mission mode (register 0x0C bit 8). The configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted generator state shows up in the very next generate. The first output word already differs from the bench's LFSR model, so nonce-seeded runs expose it within 8 cycles of the command.

A wrong latency counter or a stuck busy flag moves the edge on which a cause bit sets. The bench samples that exact cycle, and the one before it.

Faults in the auto-reseed counters show as a busy-seeding bit on the wrong cycle after the Nth request or after the age window. A lockup detection fault shows as status bit 27 or cause bit 4 missing one cycle after a zero seed.

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl #(
  parameter int          AW       = 8,
  parameter int          CW       = 16,
  parameter int          GEN_LAT  = 8,
  parameter int          SEED_LAT = 16,
  parameter logic [31:0] GEN_POLY = 32'h8020_0003,
  parameter logic [31:0] ENT_POLY = 32'hA300_0001,
  parameter logic [31:0] ENT_INIT = 32'h1F2E_3D4C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          irq
);
  localparam int LW = $clog2((GEN_LAT > SEED_LAT) ? GEN_LAT : SEED_LAT) + 1;
  localparam logic [LW-1:0] GEN_LAST  = LW'(GEN_LAT - 1);
  localparam logic [LW-1:0] SEED_LAST = LW'(SEED_LAT - 1);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_MODE = AW'(8'h08);
  localparam logic [AW-1:0] A_SCFG = AW'(8'h0C);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h10);
  localparam logic [AW-1:0] A_CAUS = AW'(8'h14);
  localparam logic [AW-1:0] A_REQ  = AW'(8'h60);
  localparam logic [AW-1:0] A_AGE  = AW'(8'h64);

  function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] p);
    return (s >> 1) ^ (s[0] ? p : 32'h0);
  endfunction

  logic [31:0]   ent_q, gst_q;
  logic [31:0]   word_q [8];
  logic          gen_busy, seed_busy, seeded, lock_d, age_due;
  logic [LW-1:0] cnt;
  logic          wide, nonce, mission;
  logic [15:0]   nonce_f;
  logic [3:0]    ien;
  logic          ien_glb;
  logic [2:0]    cause;
  logic [CW-1:0] req_rl, age_rl, req_left, age_left;

  wire        cmd_wr   = wr_en && wr_addr == A_CMD;
  wire        gen_done = gen_busy && cnt == GEN_LAST;
  wire        seed_done = seed_busy && cnt == SEED_LAST;
  wire        lock_now = seeded && gst_q == 32'h0;
  wire        age_fire = age_rl != '0 && age_left == CW'(1);
  wire        req_hit  = req_rl != '0 && req_left <= CW'(1);
  wire [31:0] seed_val = nonce ? {nonce_f, nonce_f} : ent_q;
  wire [31:0] gst_nx   = lfsr_step(gst_q, GEN_POLY);
  wire [2:0]  cause_set = {lock_now && !lock_d, seed_done, gen_done};
  wire [2:0]  cause_clr = (wr_en && wr_addr == A_CAUS) ? {wr_data[4], wr_data[1:0]} : 3'b0;

  assign irq = ien_glb && |(cause & {ien[3], ien[1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= ENT_INIT; gst_q <= '0; gen_busy <= 1'b0; seed_busy <= 1'b0;
      seeded <= 1'b0; lock_d <= 1'b0; age_due <= 1'b0; cnt <= '0;
      wide <= 1'b0; nonce <= 1'b0; mission <= 1'b0; nonce_f <= '0;
      ien <= '0; ien_glb <= 1'b0; cause <= '0;
      req_rl <= '0; age_rl <= '0; req_left <= '0; age_left <= '0;
      for (int i = 0; i < 8; i++) word_q[i] <= '0;
    end else begin
      ent_q  <= lfsr_step(ent_q, ENT_POLY);
      lock_d <= lock_now;
      cause  <= (cause & ~cause_clr) | cause_set;
      if (age_rl != '0 && age_left != '0) age_left <= age_left - 1'b1;

      if (gen_busy) begin
        cnt   <= cnt + 1'b1;
        gst_q <= gst_nx;
        if (cnt < LW'(8)) word_q[cnt[2:0]] <= gst_nx;
        if (gen_done) begin
          gen_busy <= 1'b0;
          cnt      <= '0;
          if (req_rl != '0 && !req_hit) req_left <= req_left - 1'b1;
          if (req_hit || age_fire || age_due) begin
            seed_busy <= 1'b1;
            age_due   <= 1'b0;
            req_left  <= '0;
          end
        end else if (age_fire) begin
          age_due <= 1'b1;
        end
      end else if (seed_busy) begin
        cnt <= cnt + 1'b1;
        if (seed_done) begin
          seed_busy <= 1'b0;
          cnt       <= '0;
          gst_q     <= seed_val;
          seeded    <= 1'b1;
          req_left  <= req_rl;
          age_left  <= age_rl;
          age_due   <= 1'b0;
        end
      end else if (age_fire || age_due) begin
        seed_busy <= 1'b1;
        age_due   <= 1'b0;
      end else if (cmd_wr && wr_data == 32'd1 && seeded) begin
        gen_busy <= 1'b1;
      end else if (cmd_wr && wr_data == 32'd2) begin
        seed_busy <= 1'b1;
      end

      if (wr_en) begin
        case (wr_addr)
          A_MODE: wide <= wr_data[3];
          A_SCFG: begin nonce <= wr_data[2]; mission <= wr_data[8]; nonce_f <= wr_data[31:16]; end
          A_IEN:  begin ien <= {wr_data[4], 1'b0, wr_data[1:0]}; ien_glb <= wr_data[31]; end
          A_REQ:  begin req_rl <= wr_data[CW-1:0]; req_left <= wr_data[CW-1:0]; end
          A_AGE:  begin age_rl <= wr_data[CW-1:0]; age_left <= wr_data[CW-1:0]; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[AW-1:5] == '0 && rd_addr[4:0] >= 5'h0 && rd_addr < AW'(8'h20)) begin
      case (rd_addr)
        A_STAT: begin
          rd_data[31] = seed_busy; rd_data[30] = gen_busy; rd_data[27] = lock_now;
          rd_data[9] = seeded; rd_data[8] = mission; rd_data[3] = wide; rd_data[2] = nonce;
        end
        A_MODE: rd_data[3] = wide;
        A_SCFG: begin rd_data[31:16] = nonce_f; rd_data[8] = mission; rd_data[2] = nonce; end
        A_IEN:  begin rd_data[31] = ien_glb; rd_data[4] = ien[3]; rd_data[1:0] = ien[1:0]; end
        A_CAUS: begin rd_data[4] = cause[2]; rd_data[1:0] = cause[1:0]; end
        default: ;
      endcase
    end else if (rd_addr[AW-1:5] == (AW-5)'(1)) begin
      if (wide || !rd_addr[4]) rd_data = word_q[rd_addr[4:2]];
    end else if (rd_addr == A_REQ) begin
      rd_data[CW-1:0] = req_rl;
    end else if (rd_addr == A_AGE) begin
      rd_data[CW-1:0] = age_rl;
    end
  end

  p_one_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_busy && seed_busy));
  p_gen_seeded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gen_busy |-> seeded);
  p_ready_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_busy) |-> cause[0]);
  p_seed_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seed_busy) |-> (seeded && cause[1]));
  p_lock_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_now) |=> cause[2]);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == 3'b0) |-> !irq);
endmodule

// File: tb/test_rng_cmd_ctrl.sv
module test_rng_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] m_state, v;
  logic [31:0] exp_w [8];

  rng_cmd_ctrl i_rng_cmd_ctrl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_gen();
    for (int k = 0; k < 8; k++) begin m_state = nxt(m_state); exp_w[k] = m_state; end
  endtask

  task automatic cmp_words(input string req, input bit wide);
    for (int k = 0; k < 8; k++) begin
      rd(8'h20 + 8'(4*k), v);
      chk(req, v, (wide || k < 4) ? exp_w[k] : 32'h0);
    end
  endtask

  task automatic reseed();
    wr(8'h00, 32'd2); wait_cyc(16);
  endtask

  task automatic generate_chk(input string req, input bit wide);
    wr(8'h00, 32'd1); wait_cyc(8); model_gen(); cmp_words(req, wide);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    wait_cyc(3); rst_n = 1'b1; wait_cyc(1);
    // R1 reset state
    rd(8'h04, v); chk("R1 stat", v, 32'h0);
    rd(8'h14, v); chk("R1 cause", v, 32'h0);
    rd(8'h20, v); chk("R1 word0", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R6 generate before seeding
    wr(8'h00, 32'd1);
    rd(8'h04, v); chk("R6 unseeded busy", v, 32'h0);
    wait_cyc(10); rd(8'h14, v); chk("R6 unseeded cause", v, 32'h0);

    // R12 configuration mirror
    wr(8'h10, 32'h8000_0013);
    wr(8'h0C, 32'hABCD_0104);
    wr(8'h08, 32'h8);
    rd(8'h04, v); chk("R12 stat mirror", v, 32'h0000_010C);
    rd(8'h0C, v); chk("R12 scfg readback", v, 32'hABCD_0104);
    rd(8'h10, v); chk("R12 ien readback", v, 32'h8000_0013);

    // R2 reseed timing
    wr(8'h00, 32'd2);
    rd(8'h04, v); chk("R2 seeding bit", v[31], 1'b1);
    wait_cyc(15); rd(8'h14, v); chk("R2 cause early", v, 32'h0);
    wait_cyc(1);
    rd(8'h14, v); chk("R2 seed done cause", v, 32'h2);
    rd(8'h04, v); chk("R2 seeded bit", {v[31], v[9]}, 32'b01);
    chk("R8 irq on seed done", 32'(irq), 32'h1);
    m_state = 32'hABCD_ABCD;
    wr(8'h10, 32'h0000_0013);
    chk("R8 global gate", 32'(irq), 32'h0);
    wr(8'h10, 32'h8000_0011);
    chk("R8 cause mask", 32'(irq), 32'h0);
    wr(8'h10, 32'h8000_0013);
    wr(8'h14, 32'h2);
    rd(8'h14, v); chk("R7 clear", v, 32'h0);

    // R3 generate timing and words
    wr(8'h00, 32'd1);
    rd(8'h04, v); chk("R3 generating bit", v[30], 1'b1);
    wait_cyc(7); rd(8'h14, v); chk("R3 cause early", v, 32'h0);
    wait_cyc(1); rd(8'h14, v); chk("R3 ready cause", v, 32'h1);
    model_gen(); cmp_words("R3 words", 1'b1);
    generate_chk("R3 continued words", 1'b1);

    // R7 partial clear
    reseed(); m_state = 32'hABCD_ABCD;
    rd(8'h14, v); chk("R7 both set", v, 32'h3);
    wr(8'h14, 32'h1);
    rd(8'h14, v); chk("R7 partial clear", v, 32'h2);
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R7 zero write", v, 32'h2);
    wr(8'h14, 32'h13);

    // R6 commands while busy, bad codes
    wr(8'h00, 32'd2); wr(8'h00, 32'd1); wait_cyc(25);
    rd(8'h14, v); chk("R6 gen during seed", v, 32'h2);
    rd(8'h04, v); chk("R6 idle after", v[31:30], 2'b00);
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd1); wr(8'h00, 32'd2); wait_cyc(30);
    rd(8'h14, v); chk("R6 seed during gen", v, 32'h1);
    model_gen(); cmp_words("R6 single gen", 1'b1);
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd3); rd(8'h04, v); chk("R6 code 3", v[31:30], 2'b00);
    wr(8'h00, 32'd0); rd(8'h04, v); chk("R6 code 0", v[31:30], 2'b00);
    wait_cyc(20); rd(8'h14, v); chk("R6 no cause", v, 32'h0);

    // R5 128-bit mode
    wr(8'h08, 32'h0);
    rd(8'h04, v); chk("R12 wide mirror", v[3], 1'b0);
    generate_chk("R5 narrow words", 1'b0);
    wr(8'h14, 32'h13);

    // R4 random nonces
    for (int it = 0; it < 8; it++) begin
      logic [15:0] f;
      bit wd;
      int ng;
      f  = 16'($urandom) | 16'h1;
      wd = 1'($urandom);
      ng = 1 + int'($urandom % 3);
      wr(8'h0C, {f, 16'h0004});
      wr(8'h08, {28'h0, wd, 3'b0});
      reseed(); m_state = {f, f};
      for (int g = 0; g < ng; g++) generate_chk("R4 nonce words", wd);
      wr(8'h14, 32'h13);
    end

    // R4 entropy seed
    wr(8'h0C, 32'h0); wr(8'h08, 32'h8);
    reseed(); wr(8'h00, 32'd1); wait_cyc(8);
    rd(8'h20, v); chk("R4 entropy nonzero", 32'(v != 0), 32'h1);
    for (int k = 0; k < 7; k++) begin
      logic [31:0] a;
      rd(8'h20 + 8'(4*k), a); rd(8'h24 + 8'(4*k), v);
      chk("R4 entropy chain", v, nxt(a));
    end

    // R9 request counter
    wr(8'h0C, 32'h5A5A_0004);
    reseed(); m_state = 32'h5A5A_5A5A;
    wr(8'h60, 32'd3);
    rd(8'h60, v); chk("R12 req readback", v, 32'd3);
    wr(8'h14, 32'h13);
    generate_chk("R9 gen1", 1'b1);
    generate_chk("R9 gen2", 1'b1);
    rd(8'h04, v); chk("R9 no early reseed", v[31], 1'b0);
    wr(8'h00, 32'd1); wait_cyc(8);
    rd(8'h04, v); chk("R9 auto reseed start", v[31:30], 2'b10);
    wait_cyc(15); rd(8'h14, v); chk("R9 seed cause early", v[1], 1'b0);
    wait_cyc(1); rd(8'h14, v); chk("R9 auto seed done", v[1], 1'b1);
    wr(8'h60, 32'd0);
    m_state = 32'h5A5A_5A5A;
    generate_chk("R9 fresh words", 1'b1);
    wr(8'h14, 32'h13);

    // R10 age timer
    wr(8'h64, 32'd20);
    wait_cyc(19); rd(8'h04, v); chk("R10 before expiry", v[31], 1'b0);
    wait_cyc(1);  rd(8'h04, v); chk("R10 expiry", v[31], 1'b1);
    wait_cyc(15); rd(8'h14, v); chk("R10 cause early", v, 32'h0);
    wait_cyc(1);  rd(8'h14, v); chk("R10 seed done", v, 32'h2);
    wr(8'h64, 32'd0);
    wr(8'h14, 32'h13);
    wait_cyc(40); rd(8'h04, v); chk("R10 disabled", v[31], 1'b0);

    // R11 lockup
    wr(8'h0C, 32'h0000_0004);
    wr(8'h00, 32'd2); wait_cyc(16);
    rd(8'h04, v); chk("R11 service flag", v[27], 1'b1);
    rd(8'h14, v); chk("R11 cause not yet", v[4], 1'b0);
    wait_cyc(1);
    rd(8'h14, v); chk("R11 lock cause", v, 32'h12);
    chk("R11 irq", 32'(irq), 32'h1);
    m_state = 32'h0;
    generate_chk("R11 zero words", 1'b1);
    wr(8'h14, 32'h13);
    rd(8'h14, v); chk("R11 cleared stays", v, 32'h0);
    wr(8'h0C, 32'h1234_0004);
    reseed(); m_state = 32'h1234_1234;
    rd(8'h04, v); chk("R11 recovered", v[27], 1'b0);
    generate_chk("R11 recovered words", 1'b1);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule